// File: doc/BRIEF.md
# Bus Clock Loss Monitor

This block watches a bus clock that arrives from outside and raises an alarm when that clock stops toggling. A faster reference clock runs all the time and samples the bus clock. A stalled clock is caught whether it sticks high or sticks low. The alarm clears on the first transition that comes through after the stall. A sticky copy of the alarm holds the event until it is explicitly cleared.

A parameter selects one of two variants. The drop variant works against a time threshold that is set in nanoseconds. The add variant works against a count of missing bus-clock periods. While its alarm is active, the add variant also puts its data and parity outputs into high impedance and forces its add indicator low. The quiet-time limit is always held as a number of reference cycles, which the block derives from its parameters.

Top module: `bus_clk_loss_mon`

## Requirements
- R1: While reset is held, `alarm_o` and `alarm_sticky_o` are 0 and `add_oe_o` is 1.
- R2: After the last level change of `mon_clk_i`, `alarm_o` rises at the (LIMIT+3)-th rising reference edge and not before. The count includes two synchronizer stages and one stage of change detection. If the level changes again before that edge, no alarm occurs. This holds for a clock stuck high and for a clock stuck low.
- R3: In the drop variant, LIMIT is DROP_NS/REF_NS. With the defaults, LIMIT is 1000/10 = 100 cycles. The alarm therefore comes 1030 ns after the stall begins, which is within the window of 500 ns to 1500 ns.
- R4: In the add variant, LIMIT is ADD_PERIODS*BUS_REF_CYC. With the defaults, LIMIT is 10 bus periods of 4 reference cycles each, which is 40 cycles.
- R5: An active alarm is low after the third rising reference edge that follows the first level change of `mon_clk_i`. It stays high until then.
- R6: In the add variant, `add_oe_o` is a register that goes low at the edge after `alarm_o` is first seen high, and returns high at the edge after `alarm_o` is seen low. While `add_oe_o` is 0, every bit of `add_dat_o` and of `add_par_o` is high impedance. While `add_oe_o` is 1, those outputs follow `add_dat_i` and `add_par_i`.
- R7: `add_ind_o` equals `add_ind_i` AND `add_oe_o`.
- R8: `alarm_sticky_o` becomes 1 at the edge after `alarm_o` is seen high. It stays 1 until `sticky_clr_i` is sampled high while `alarm_o` is low. If the clear and an active alarm meet in the same cycle, the set wins.
- R9: In the drop variant, `add_oe_o` is always 1. The data, parity and indicator outputs follow their inputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| mon_clk_i | input | 1 | Monitored bus clock, asynchronous to `clk` |
| sticky_clr_i | input | 1 | Clears the sticky alarm |
| add_dat_i | input | DW | Add-bus data to be driven |
| add_par_i | input | 1 | Add-bus parity to be driven |
| add_ind_i | input | 1 | Add indicator request |
| alarm_o | output | 1 | Live clock-loss alarm |
| alarm_sticky_o | output | 1 | Sticky copy of the alarm |
| add_oe_o | output | 1 | Registered output enable, low while the alarm is active |
| add_dat_o | output | DW | Add-bus data, high impedance when disabled |
| add_par_o | output | 1 | Add-bus parity, high impedance when disabled |
| add_ind_o | output | 1 | Gated add indicator |

## Verification
The assertions check several rules on every cycle:
- a detected transition takes down an active alarm on the next edge, and a quiet clock keeps the alarm up;
- the output enable follows the alarm one cycle later;
- the sticky bit sets, holds and clears as R8 states.

Only the bench scenarios can show three things. First, the exact onset cycle, LIMIT+3 edges after a level change, measured from the pin for holds of every length around the threshold and at both stuck levels. Second, that the drop limit lands inside its time tolerance. Third, that the driven outputs actually go to high impedance and come back.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic {
    MODE_DROP = 1'b0,
    MODE_ADD  = 1'b1
  } lm_mode_e;

  // Quiet-time limit in reference cycles for the selected variant.
  function automatic int lm_limit(input lm_mode_e mode, input int ref_ns,
                                  input int drop_ns, input int add_periods,
                                  input int bus_ref_cyc);
    if (mode == MODE_ADD) return add_periods * bus_ref_cyc;
    return drop_ns / ref_ns;
  endfunction

endpackage

// File: rtl/lm_rst_sync.sv
module lm_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] rst_q;
  logic [1:0] rst_d;

  always_comb begin
    rst_d = {rst_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_q <= 2'b00;
    else          rst_q <= rst_d;
  end

  assign rst_n_o = rst_q[1];

endmodule

// File: rtl/lm_edge_sync.sv
module lm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);

  // [STAGES-1:0] form the synchronizer chain; [STAGES] keeps the prior level.
  logic [STAGES:0] sync_q;
  logic [STAGES:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign edge_o = sync_q[STAGES] ^ sync_q[STAGES-1];

endmodule

// File: rtl/lm_stall_timer.sv
module lm_stall_timer #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic sticky_clr_i,
  output logic alarm_o,
  output logic sticky_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          sticky_q, sticky_d;

  always_comb begin
    cnt_en   = edge_i || (cnt_q != LIM_C);
    cnt_d    = edge_i ? '0 : cnt_q + CW'(1);
    sticky_d = alarm_o | (sticky_q & ~sticky_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      sticky_q <= sticky_d;
    end
  end

  assign alarm_o  = (cnt_q == LIM_C);
  assign sticky_o = sticky_q;

  // R5
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !alarm_o);

  // R2
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !edge_i) |=> alarm_o);

  // R2
  alarm_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> $past(!edge_i));

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> sticky_o);

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_o && !sticky_clr_i) |=> sticky_o);

  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_o && sticky_clr_i) |=> !sticky_o);

endmodule

// File: rtl/lm_out_gate.sv
module lm_out_gate #(
  parameter bit GATE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_i,
  input  logic ind_i,
  output logic oe_o,
  output logic ind_o
);

  generate
    if (GATE) begin : g_gate
      logic oe_q, oe_d;

      always_comb begin
        oe_d = ~alarm_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b1;
        else        oe_q <= oe_d;
      end

      assign oe_o  = oe_q;
      assign ind_o = ind_i & oe_q;

      // R6
      oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_i |=> !oe_o);

      // R6
      oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_i |=> oe_o);
    end else begin : g_pass
      assign oe_o  = 1'b1;
      assign ind_o = ind_i;
    end
  endgenerate

endmodule

// File: rtl/bus_clk_loss_mon.sv
module bus_clk_loss_mon #(
  parameter lm_pkg::lm_mode_e MODE = lm_pkg::MODE_ADD,
  parameter int REF_NS      = 10,
  parameter int DROP_NS     = 1000,
  parameter int ADD_PERIODS = 10,
  parameter int BUS_REF_CYC = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mon_clk_i,
  input  logic          sticky_clr_i,
  input  logic [DW-1:0] add_dat_i,
  input  logic          add_par_i,
  input  logic          add_ind_i,
  output logic          alarm_o,
  output logic          alarm_sticky_o,
  output logic          add_oe_o,
  output logic [DW-1:0] add_dat_o,
  output logic          add_par_o,
  output logic          add_ind_o
);

  localparam int  LIMIT = lm_pkg::lm_limit(MODE, REF_NS, DROP_NS, ADD_PERIODS, BUS_REF_CYC);
  localparam bit  GATE  = (MODE == lm_pkg::MODE_ADD);

  logic rst_n_s;
  logic mon_edge;
  logic alarm;
  logic oe;

  lm_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  lm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (mon_clk_i),
    .edge_o  (mon_edge)
  );

  lm_stall_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .edge_i       (mon_edge),
    .sticky_clr_i (sticky_clr_i),
    .alarm_o      (alarm),
    .sticky_o     (alarm_sticky_o)
  );

  lm_out_gate #(.GATE(GATE)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .alarm_i (alarm),
    .ind_i   (add_ind_i),
    .oe_o    (oe),
    .ind_o   (add_ind_o)
  );

  assign alarm_o   = alarm;
  assign add_oe_o  = oe;
  assign add_dat_o = oe ? add_dat_i : {DW{1'bz}};
  assign add_par_o = oe ? add_par_i : 1'bz;

endmodule

// File: tb/bus_clk_loss_mon_test.sv
module bus_clk_loss_mon_test;

  localparam int DW = 8;
  localparam int LA = 40;   // add variant: 10 periods * 4 reference cycles
  localparam int LD = 100;  // drop variant: 1000 ns / 10 ns

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, mon, clr, pin, iin;
  logic [DW-1:0] din;

  logic alarm_a, stk_a, oe_a, ind_a;
  wire  [DW-1:0] dat_a;
  wire  par_a;
  logic alarm_d, stk_d, oe_d, ind_d;
  wire  [DW-1:0] dat_d;
  wire  par_d;

  bus_clk_loss_mon #(.MODE(lm_pkg::MODE_ADD), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mon_clk_i(mon), .sticky_clr_i(clr),
    .add_dat_i(din), .add_par_i(pin), .add_ind_i(iin),
    .alarm_o(alarm_a), .alarm_sticky_o(stk_a), .add_oe_o(oe_a),
    .add_dat_o(dat_a), .add_par_o(par_a), .add_ind_o(ind_a));

  bus_clk_loss_mon #(.MODE(lm_pkg::MODE_DROP), .DW(DW)) uut_drop (
    .clk(clk), .rst_n(rst_n), .mon_clk_i(mon), .sticky_clr_i(clr),
    .add_dat_i(din), .add_par_i(pin), .add_ind_i(iin),
    .alarm_o(alarm_d), .alarm_sticky_o(stk_d), .add_oe_o(oe_d),
    .add_dat_o(dat_d), .add_par_o(par_d), .add_ind_o(ind_d));

  int checks = 0;
  int errors = 0;
  int ec = 0;
  int tog [4];
  bit clr_now = 1'b0;
  bit sa_exp = 1'b0;
  bit sd_exp = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, ec, act, exp);
    end
  endtask

  // Alarm level expected after reference edge e: measured from the most
  // recent level change that has passed the three-edge input latency.
  function automatic bit exp_alarm(input int e, input int lim);
    for (int k = 0; k < 4; k++) begin
      if (tog[k] >= 0 && e - tog[k] >= 3) return (e - tog[k] - 3) >= lim;
    end
    return 1'b0;
  endfunction

  task automatic step();
    bit ea, pa, eoe, ed, pd;
    logic [DW-1:0] xd;
    logic xp;
    @(posedge clk);
    ec++;
    @(negedge clk);
    // add variant
    ea  = exp_alarm(ec, LA);
    pa  = exp_alarm(ec - 1, LA);
    eoe = !pa;
    chk(alarm_a == ea, ea ? "R4" : (pa ? "R5" : "R2"), "add alarm", 64'(alarm_a), 64'(ea));
    chk(oe_a == eoe, "R6", "add oe", 64'(oe_a), 64'(eoe));
    xd = eoe ? din : {DW{1'bz}};
    xp = eoe ? pin : 1'bz;
    chk(dat_a === xd, "R6", "add data", 64'(dat_a), 64'(xd));
    chk(par_a === xp, "R6", "add parity", 64'(par_a), 64'(xp));
    chk(ind_a == (iin & eoe), "R7", "add indicator", 64'(ind_a), 64'(iin & eoe));
    sa_exp = pa | (sa_exp & !clr_now);
    chk(stk_a == sa_exp, "R8", "add sticky", 64'(stk_a), 64'(sa_exp));
    // drop variant
    ed = exp_alarm(ec, LD);
    pd = exp_alarm(ec - 1, LD);
    chk(alarm_d == ed, ed ? "R3" : (pd ? "R5" : "R2"), "drop alarm", 64'(alarm_d), 64'(ed));
    chk(oe_d == 1'b1, "R9", "drop oe", 64'(oe_d), 64'(1));
    chk(dat_d === din, "R9", "drop data", 64'(dat_d), 64'(din));
    chk(par_d === pin, "R9", "drop parity", 64'(par_d), 64'(pin));
    chk(ind_d === iin, "R9", "drop indicator", 64'(ind_d), 64'(iin));
    sd_exp = pd | (sd_exp & !clr_now);
    chk(stk_d == sd_exp, "R8", "drop sticky", 64'(stk_d), 64'(sd_exp));
    // new data pattern for the next cycle
    din = din + 8'h35;
    pin = ^din;
    iin = ~iin;
  endtask

  // Change the monitored level, then keep it for h reference edges.
  task automatic hold(input int h, input int clr_at);
    mon = ~mon;
    for (int k = 3; k > 0; k--) tog[k] = tog[k-1];
    tog[0] = ec;
    for (int j = 1; j <= h; j++) begin
      clr = (j == clr_at);
      clr_now = clr;
      step();
    end
    clr = 1'b0;
    clr_now = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) tog[k] = -1;
    rst_n = 1'b0; mon = 1'b0; clr = 1'b0; din = 8'h5a; pin = 1'b0; iin = 1'b1;
    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(alarm_a == 1'b0 && alarm_d == 1'b0, "R1", "alarm in reset", 64'({alarm_a, alarm_d}), 64'(0));
      chk(stk_a == 1'b0 && stk_d == 1'b0, "R1", "sticky in reset", 64'({stk_a, stk_d}), 64'(0));
      chk(oe_a == 1'b1 && oe_d == 1'b1, "R1", "oe in reset", 64'({oe_a, oe_d}), 64'(3));
    end
    rst_n = 1'b1;
    step();
    step();
    // R2 R4 R5 R6: sweep hold lengths across the add threshold, both levels
    for (int rep = 0; rep < 2; rep++) begin
      for (int h = 1; h <= LA + 6; h++) hold(h, 0);
      hold(1, 0);
    end
    // R8: clear after the alarm has gone, then set wins over clear
    hold(5, 4);
    hold(LA + 8, LA + 6);
    hold(6, 5);
    // R3: sweep around the drop threshold
    for (int h = LD - 2; h <= LD + 5; h++) hold(h, 0);
    hold(8, 7);
    // R2: a running clock with short, uneven half periods
    for (int k = 0; k < 24; k++) hold(1 + (k % 3), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule